// File: doc/BRIEF.md
# Cluster-Classifier Gated CAM

A binary content-addressable memory whose storage is divided into sub-blocks that can each be switched into comparison independently. A classifier in front of the array examines only a short, fixed selection of search-tag bits. That short key is cut into equal fields. Each field is decoded one-hot into a cluster of input neurons. A per-entry connection table then predicts which entries could possibly hold the tag. Only the sub-blocks that hold at least one predicted entry run a full-width compare. All other sub-blocks stay idle.

Entries are added, replaced or removed through a single write port. The port edits only the connection bits that belong to the addressed entry, so the classifier never needs retraining. A search takes two cycles: classification first, then the gated compare. The result reports a hit flag, the lowest matching index, and the mask of sub-blocks that were enabled.

Top module: `ccgc_top`

## Requirements
- R1: After reset, no entry is valid: every search returns hit 0, index 0 and an all-zero sub-block mask, and outputs stay zero while no result is being presented.
- R2: A search accepted while srch_en is high in a cycle presents its result with res_valid high exactly two rising edges later, and res_valid is low in every other cycle.
- R3: A search whose full tag equals the tag of a valid entry returns hit 1 and that entry's index.
- R4: A search that equals no valid entry's full tag returns hit 0 and index 0.
- R5: The short key is built from tag bits 3, 7, 11, 15, 19, 23, 27 and 31, with key bit i taken from tag bit 4i+3. Sub-block b covers entries 8b to 8b+7. Mask bit b is 1 exactly when some valid entry in sub-block b has the same short key as the search tag.
- R6: Whenever a hit is reported, the mask bit of the sub-block holding the reported index is 1 (a stored tag is never lost by the classifier).
- R7: When several valid entries hold the searched tag, the lowest index is reported.
- R8: A delete (wr_del 1) makes the entry invalid. It no longer hits and no longer contributes to the mask. All other entries keep their hits and mask contributions.
- R9: Writing a new tag to an occupied index removes every effect of the old tag (no hit, no mask contribution) and installs the new one.
- R10: An entry whose short key matches but whose full tag differs enables its sub-block but does not produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write-port operation strobe |
| wr_del | input | 1 | 1 = delete entry, 0 = store tag |
| wr_idx | input | 6 | Entry index for the write port |
| wr_tag | input | 32 | Tag to store |
| srch_en | input | 1 | Start a search |
| srch_tag | input | 32 | Tag to look up |
| res_valid | output | 1 | Search result is presented |
| res_hit | output | 1 | A valid entry holds the tag |
| res_idx | output | 6 | Lowest matching entry index, 0 on miss |
| res_blk_mask | output | 8 | Sub-blocks that were enabled for compare |

## Verification
Searches use tags drawn from a pool with only a few distinct short keys, so that many entries alias in the classifier. This separates sub-block masking from the final compare and shows false positives being filtered out. Directed sequences store one tag at two indices, then delete and overwrite entries. These cases distinguish lowest-index priority from stale connection bits left behind by a delete or an overwrite. A long random mix of stores, deletes and searches checks hit, index and mask against a bench model on every search. Searches on an empty array and on keys held by no entry cover the all-miss case.

// File: rtl/ccgc_pkg.sv
package ccgc_pkg;
   typedef enum logic {
      WR_ADD = 1'b0,
      WR_DEL = 1'b1
   } wr_op_e;
endpackage

// File: rtl/ccgc_local_dec.sv
module ccgc_local_dec #(
   parameter int unsigned K_BITS = 4,
   localparam int unsigned L = 1 << K_BITS
) (
   input  logic [K_BITS-1:0] val,
   output logic [L-1:0]      onehot
);
   always_comb begin
      onehot = '0;
      onehot[val] = 1'b1;
   end
endmodule

// File: rtl/ccgc_conn_bank.sv
module ccgc_conn_bank #(
   parameter int unsigned K_BITS  = 4,
   parameter int unsigned ENTRIES = 64,
   localparam int unsigned L      = 1 << K_BITS,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic               clr_en,
   input  logic [K_BITS-1:0]  clr_nrn,
   input  logic               set_en,
   input  logic [K_BITS-1:0]  set_nrn,
   input  logic [K_BITS-1:0]  key_nrn,
   output logic [ENTRIES-1:0] row
);
   logic [L-1:0][ENTRIES-1:0] conn_q;
   logic [L-1:0]              key_oh;

   ccgc_local_dec #(.K_BITS(K_BITS)) u_dec (.val(key_nrn), .onehot(key_oh));

   // clear of the old neuron first, set of the new one wins on overlap
   always_ff @(posedge clk) begin
      if (rst) begin
         conn_q <= '0;
      end else begin
         if (clr_en) conn_q[clr_nrn][upd_idx] <= 1'b0;
         if (set_en) conn_q[set_nrn][upd_idx] <= 1'b1;
      end
   end

   always_comb begin
      row = '0;
      for (int n = 0; n < int'(L); n++)
         if (key_oh[n]) row = row | conn_q[n];
   end
endmodule

// File: rtl/ccgc_subblock_cmp.sv
module ccgc_subblock_cmp #(
   parameter int unsigned BLK   = 8,
   parameter int unsigned TAG_W = 32
) (
   input  logic                      en,
   input  logic [BLK-1:0]            cand,
   input  logic [BLK-1:0]            vld,
   input  logic [BLK-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]          key,
   output logic [BLK-1:0]            match
);
   always_comb begin
      match = '0;
      if (en) begin
         for (int w = 0; w < int'(BLK); w++)
            match[w] = cand[w] && vld[w] && (tags[w] == key);
      end
   end
endmodule

// File: rtl/ccgc_top.sv
module ccgc_top
   import ccgc_pkg::*;
#(
   parameter int unsigned  ENTRIES  = 64,
   parameter int unsigned  TAG_W    = 32,
   parameter int unsigned  K_BITS   = 4,
   parameter int unsigned  CLUSTERS = 2,
   parameter int unsigned  BLK      = 8,
   parameter logic [255:0] RED_POS  = 256'h1F1B17130F0B0703,
   localparam int unsigned IDX_W    = $clog2(ENTRIES),
   localparam int unsigned BLKS     = ENTRIES / BLK
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_del,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             srch_en,
   input  logic [TAG_W-1:0] srch_tag,
   output logic             res_valid,
   output logic             res_hit,
   output logic [IDX_W-1:0] res_idx,
   output logic [BLKS-1:0]  res_blk_mask
);
   localparam int unsigned Q = K_BITS * CLUSTERS;

   // elaboration checks
   if (Q > 32 || Q > TAG_W) begin : g_chk_q
      $error("short key wider than tag or position table");
   end
   if ((ENTRIES % BLK) != 0 || (1 << IDX_W) != ENTRIES
       || (1 << $clog2(BLK)) != BLK) begin : g_chk_geom
      $error("entry count and sub-block size must be powers of two");
   end
   for (genvar i = 0; i < int'(Q); i++) begin : g_chk_pos
      if (RED_POS[8*i +: 8] >= TAG_W) begin : g_bad
         $error("short-key bit position outside the tag");
      end
   end

   function automatic logic [Q-1:0] reduce(input logic [TAG_W-1:0] t);
      logic [Q-1:0] r;
      for (int i = 0; i < int'(Q); i++)
         r[i] = |(t & (TAG_W'(1) << RED_POS[8*i +: 8]));
      return r;
   endfunction

   // entry storage
   logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
   logic [ENTRIES-1:0]            vld_q;
   wr_op_e                        op;

   assign op = wr_del ? WR_DEL : WR_ADD;

   always_ff @(posedge clk) begin
      if (rst)        vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= (op == WR_ADD);
   end

   always_ff @(posedge clk) begin
      if (wr_en && op == WR_ADD) tag_q[wr_idx] <= wr_tag;
   end

   // classifier
   logic [Q-1:0] old_red, new_red, key_red;
   logic [CLUSTERS-1:0][ENTRIES-1:0] rows;
   logic [ENTRIES-1:0] cand;

   assign old_red = reduce(tag_q[wr_idx]);
   assign new_red = reduce(wr_tag);
   assign key_red = reduce(srch_tag);

   for (genvar c = 0; c < int'(CLUSTERS); c++) begin : g_cl
      ccgc_conn_bank #(.K_BITS(K_BITS), .ENTRIES(ENTRIES)) u_bank (
         .clk     (clk),
         .rst     (rst),
         .upd_idx (wr_idx),
         .clr_en  (wr_en && vld_q[wr_idx]),
         .clr_nrn (old_red[c*K_BITS +: K_BITS]),
         .set_en  (wr_en && op == WR_ADD),
         .set_nrn (new_red[c*K_BITS +: K_BITS]),
         .key_nrn (key_red[c*K_BITS +: K_BITS]),
         .row     (rows[c])
      );
   end

   always_comb begin
      cand = '1;
      for (int c = 0; c < int'(CLUSTERS); c++) cand = cand & rows[c];
   end

   // stage 1: classify
   logic               s1_vld;
   logic [TAG_W-1:0]   s1_tag;
   logic [ENTRIES-1:0] s1_cand;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld  <= 1'b0;
         s1_cand <= '0;
      end else begin
         s1_vld  <= srch_en;
         s1_cand <= cand;
      end
      s1_tag <= srch_tag;
   end

   // stage 2: gated compare
   logic [BLKS-1:0]    blk_en;
   logic [ENTRIES-1:0] match;

   for (genvar b = 0; b < int'(BLKS); b++) begin : g_blk
      assign blk_en[b] = |s1_cand[b*BLK +: BLK];
      ccgc_subblock_cmp #(.BLK(BLK), .TAG_W(TAG_W)) u_cmp (
         .en    (blk_en[b]),
         .cand  (s1_cand[b*BLK +: BLK]),
         .vld   (vld_q[b*BLK +: BLK]),
         .tags  (tag_q[b*BLK +: BLK]),
         .key   (s1_tag),
         .match (match[b*BLK +: BLK])
      );
   end

   logic             hit_c;
   logic [IDX_W-1:0] idx_c;

   always_comb begin
      hit_c = |match;
      idx_c = '0;
      for (int e = int'(ENTRIES) - 1; e >= 0; e--)
         if (match[e]) idx_c = IDX_W'(e);
   end

   always_ff @(posedge clk) begin
      if (rst || !s1_vld) begin
         res_valid    <= 1'b0;
         res_hit      <= 1'b0;
         res_idx      <= '0;
         res_blk_mask <= '0;
      end else begin
         res_valid    <= 1'b1;
         res_hit      <= hit_c;
         res_idx      <= idx_c;
         res_blk_mask <= blk_en;
      end
   end
endmodule

// File: rtl/ccgc_chk.sv
module ccgc_chk #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned BLK     = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned BLK_W  = $clog2(BLK),
   localparam int unsigned BLKS   = ENTRIES / BLK
) (
   input logic               clk,
   input logic               rst,
   input logic               srch_en,
   input logic               res_valid,
   input logic               res_hit,
   input logic [IDX_W-1:0]   res_idx,
   input logic [BLKS-1:0]    res_blk_mask,
   input logic [ENTRIES-1:0] entry_vld
);
   logic [1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[0], srch_en};
   end

   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      res_valid == sh_q[1]);

   a_r6_hit_in_mask: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_hit) |-> res_blk_mask[res_idx >> BLK_W]);

   a_r4_miss_idx_zero: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_hit) |-> (res_idx == '0));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> (!res_hit && res_blk_mask == '0));

   a_r5_empty_no_mask: assert property (@(posedge clk) disable iff (rst)
      (res_valid && $past(entry_vld, 2) == '0) |-> (res_blk_mask == '0 && !res_hit));
endmodule

bind ccgc_top ccgc_chk #(.ENTRIES(ENTRIES), .BLK(BLK)) chk_i (
   .clk          (clk),
   .rst          (rst),
   .srch_en      (srch_en),
   .res_valid    (res_valid),
   .res_hit      (res_hit),
   .res_idx      (res_idx),
   .res_blk_mask (res_blk_mask),
   .entry_vld    (vld_q)
);

// File: tb/ccgc_top_tb.sv
`timescale 1ns/1ps
module ccgc_top_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0, wr_del = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [31:0] wr_tag = '0;
   logic        srch_en = 1'b0;
   logic [31:0] srch_tag = '0;
   logic        res_valid, res_hit;
   logic [5:0]  res_idx;
   logic [7:0]  res_blk_mask;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] m_tag [64];
   logic        m_vld [64];

   always #2.5 clk = ~clk;

   ccgc_top dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_del(wr_del), .wr_idx(wr_idx),
      .wr_tag(wr_tag), .srch_en(srch_en), .srch_tag(srch_tag),
      .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
      .res_blk_mask(res_blk_mask)
   );

   function automatic logic [7:0] red8(input logic [31:0] t);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = t[4*i+3];
      return r;
   endfunction

   function automatic logic [31:0] with_red(input logic [31:0] t, input logic [7:0] r);
      logic [31:0] o = t;
      for (int i = 0; i < 8; i++) o[4*i+3] = r[i];
      return o;
   endfunction

   function automatic logic [7:0] exp_mask(input logic [31:0] t);
      logic [7:0] m = '0;
      for (int e = 0; e < 64; e++)
         if (m_vld[e] && red8(m_tag[e]) == red8(t)) m[e/8] = 1'b1;
      return m;
   endfunction

   function automatic int exp_idx(input logic [31:0] t);
      for (int e = 0; e < 64; e++)
         if (m_vld[e] && m_tag[e] == t) return e;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input int idx, input logic [31:0] t, input bit del);
      @(negedge clk);
      wr_en = 1'b1; wr_del = del; wr_idx = 6'(idx); wr_tag = t;
      @(negedge clk);
      wr_en = 1'b0; wr_del = 1'b0;
      m_vld[idx] = !del;
      if (!del) m_tag[idx] = t;
   endtask

   task automatic do_search(input logic [31:0] t, input string req);
      int ei;
      logic [7:0] em;
      ei = exp_idx(t);
      em = exp_mask(t);
      @(negedge clk);
      srch_en = 1'b1; srch_tag = t;
      @(negedge clk);
      srch_en = 1'b0;
      check(res_valid == 1'b0, "R2 early valid", res_valid, 0);
      @(negedge clk);
      check(res_valid == 1'b1, "R2 valid at two edges", res_valid, 1);
      check(res_hit == (ei >= 0), {req, " hit"}, res_hit, ei >= 0);
      check(res_idx == ((ei >= 0) ? 6'(ei) : 6'd0), {req, " idx"}, res_idx, (ei >= 0) ? ei : 0);
      check(res_blk_mask == em, "R5 mask", res_blk_mask, em);
      @(negedge clk);
      check(res_valid == 1'b0 && res_blk_mask == 8'd0, "R1 idle outputs quiet", res_blk_mask, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] ta, tb, tc;
      void'($urandom(32'd1234));
      for (int e = 0; e < 64; e++) begin m_vld[e] = 1'b0; m_tag[e] = '0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(res_valid == 1'b0 && res_hit == 1'b0, "R1 reset outputs", res_valid, 0);
      do_search(32'h0000_0000, "R1 empty");
      do_search(32'hFFFF_FFFF, "R1 empty");

      ta = with_red(32'h1234_5670, 8'h5A);
      tb = with_red(32'h0BAD_F000, 8'h5A);
      tc = with_red(32'h7777_0000, 8'hC3);
      do_write(5, ta, 1'b0);
      do_search(ta, "R3");
      do_write(13, tb, 1'b0);
      do_search(ta, "R3");
      do_search(with_red(32'h0000_0001, 8'h5A), "R10 false positive");
      do_write(2, ta, 1'b0);
      do_search(ta, "R7 lowest wins");
      do_write(2, 32'h0, 1'b1);
      do_search(ta, "R8 delete");
      do_search(tb, "R8 others kept");
      do_write(5, tc, 1'b0);
      do_search(ta, "R9 old tag gone");
      do_search(tc, "R9 new tag");
      do_search(with_red(32'h0, 8'h00), "R4 miss");

      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom_range(0, 9));
         int idx = int'($urandom_range(0, 63));
         logic [31:0] t = with_red($urandom(), 8'($urandom_range(0, 3)));
         if (op < 4) do_write(idx, t, 1'b0);
         else if (op < 5) do_write(idx, t, 1'b1);
         else if (op < 8 && m_vld[idx]) do_search(m_tag[idx], "R3 R7 random stored");
         else do_search(t, "R4 R10 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule